// File: doc/BRIEF.md
# Password-Unlocked Test Control Register

This block is a single 32-bit test control register for a non-volatile memory controller. A test-unlock flag guards every test field. Software raises the flag by writing one fixed 32-bit key word. The flag drops on any ordinary write whose top bit is 0. An ordinary write can never raise the flag.

While the flag is up, software can program four things:
- an eight-bit forced ECC syndrome, used by a logic self-check of the ECC path;
- a margin-read enable, together with a level select (erased or programmed);
- an ECC-check enable;
- a scratch bit that has no function.

Field access needs two more things besides the unlock flag: the external operation-done qualifier and the array-integrity-done qualifier must both be high. When access is closed, writes leave the fields untouched. Reads return zero in the field positions. Zero stands in for data the design leaves undefined there.

The registered field values are driven to downstream logic. These outputs are held inactive whenever the unlock flag is down. The register is accessed through a plain strobe bus. The write data is taken on the clock edge while `wrEn` is high. Read data is combinational and is valid while `rdEn` is high.

Top module: `nvm_test_ctrl`

## Requirements
- R1: After reset the unlock flag, all fields, all field outputs and `rdData` are 0.
- R2: A write of exactly 0xF9F99999 sets the unlock flag (`rdData` bit 31) on the next cycle and changes no field.
- R3: A non-key write with bit 31 = 1 never sets a clear unlock flag, and it leaves a set flag set.
- R4: A non-key write with bit 31 = 0 clears the unlock flag on the next cycle.
- R5: While the unlock flag is 0, writes leave every field unchanged, and field positions read as 0.
- R6: While `opDone` or `integrityDone` is low, writes leave every field unchanged, and field positions read as 0.
- R7: Bits 30:24, 15:7 and 2:0 of `rdData` always read 0, whatever was written.
- R8: Field layout on both write and read: syndrome in bits 23:16, scratch in bit 6, margin-read enable in bit 5, margin level in bit 4 (1 = erased, 0 = programmed), ECC-check enable in bit 3.
- R9: `syndromeOut`, `marginEnOut`, `marginLvlOut` and `eccEnOut` equal the stored fields while the unlock flag is 1, and are 0 while it is 0.
- R10: A clearing write (R4) made while access is open loads the fields from the same write data, in the same cycle that the flag clears.
- R11: `rdData` is 0 while `rdEn` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| wrEn | input | 1 | Write strobe |
| rdEn | input | 1 | Read strobe |
| wrData | input | 32 | Write data |
| rdData | output | 32 | Read data (combinational) |
| opDone | input | 1 | Operation-done qualifier |
| integrityDone | input | 1 | Array-integrity-done qualifier |
| syndromeOut | output | 8 | Forced syndrome value to the ECC check |
| marginEnOut | output | 1 | Margin-read enable |
| marginLvlOut | output | 1 | Margin level select |
| eccEnOut | output | 1 | ECC logic check enable |

## Verification
A single ordinary write can do two things in one cycle when bit 31 is 0 and access is open: it clears the unlock flag and it loads the fields. The bench provokes this with a directed all-ones-except-bit-31 write, and it also lets random traffic hit the case.

The flag clear shows at once: the field outputs and the read-back fields drop to zero. The loaded values are hidden at that point. The bench brings them out by writing the key again, which by itself must not touch the fields, and then reading. Random writes mixed with key writes and toggled qualifiers are checked against a bench model after every write.

// File: rtl/nvm_test_ctrl_pkg.sv
`timescale 1ns/1ps
package nvm_test_ctrl_pkg;

  localparam int DATA_W = 32;
  localparam int SYN_W  = 8;

  localparam logic [DATA_W-1:0] UNLOCK_KEY = 32'hF9F9_9999;

  // bit positions of the register image
  localparam int EN_POS      = 31;
  localparam int SYN_LSB     = 16;
  localparam int SYN_MSB     = SYN_LSB + SYN_W - 1;
  localparam int SCRATCH_POS = 6;
  localparam int MRGEN_POS   = 5;
  localparam int MRGLVL_POS  = 4;
  localparam int ECCEN_POS   = 3;

  typedef struct packed {
    logic setEn;
    logic clrEn;
    logic loadFields;
  } ctrlStrb_t;

  typedef struct packed {
    logic [SYN_W-1:0] syndrome;
    logic             scratch;
    logic             marginEn;
    logic             marginLvl;
    logic             eccEn;
  } fields_t;

  localparam int FIELDS_W = $bits(fields_t);

endpackage

// File: rtl/nvm_test_ctrl_decode.sv
`timescale 1ns/1ps
module nvm_test_ctrl_decode
  import nvm_test_ctrl_pkg::*;
#(
  parameter logic [DATA_W-1:0] KEY = UNLOCK_KEY
) (
  input  logic              wrEn,
  input  logic [DATA_W-1:0] wrData,
  input  logic              testEn,
  input  logic              opDone,
  input  logic              integrityDone,
  output ctrlStrb_t         strb
);

  logic keyHit;
  logic accessOpen;

  always_comb begin
    keyHit          = (wrData == KEY);
    accessOpen      = testEn && opDone && integrityDone;
    strb.setEn      = wrEn && keyHit;
    strb.clrEn      = wrEn && !keyHit && !wrData[EN_POS];
    strb.loadFields = wrEn && !keyHit && accessOpen;
  end

endmodule

// File: rtl/nvm_test_ctrl_datapath.sv
`timescale 1ns/1ps
module nvm_test_ctrl_datapath
  import nvm_test_ctrl_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  ctrlStrb_t         strb,
  input  logic [DATA_W-1:0] wrData,
  input  logic              rdEn,
  input  logic              opDone,
  input  logic              integrityDone,
  output logic              testEn,
  output logic [DATA_W-1:0] rdData,
  output logic [SYN_W-1:0]  syndromeOut,
  output logic              marginEnOut,
  output logic              marginLvlOut,
  output logic              eccEnOut
);

  fields_t fieldsQ;
  fields_t fieldsD;
  logic    enQ;
  logic    readOpen;

  // unpack write data into the field layout
  always_comb begin
    fieldsD.syndrome  = wrData[SYN_MSB:SYN_LSB];
    fieldsD.scratch   = wrData[SCRATCH_POS];
    fieldsD.marginEn  = wrData[MRGEN_POS];
    fieldsD.marginLvl = wrData[MRGLVL_POS];
    fieldsD.eccEn     = wrData[ECCEN_POS];
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)            enQ <= 1'b0;
    else if (strb.setEn)  enQ <= 1'b1;
    else if (strb.clrEn)  enQ <= 1'b0;
  end

  // one flop per syndrome bit, each gated by the same load strobe
  for (genvar b = 0; b < SYN_W; b++) begin : g_syn
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)                fieldsQ.syndrome[b] <= 1'b0;
      else if (strb.loadFields) fieldsQ.syndrome[b] <= fieldsD.syndrome[b];
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      fieldsQ.scratch   <= 1'b0;
      fieldsQ.marginEn  <= 1'b0;
      fieldsQ.marginLvl <= 1'b0;
      fieldsQ.eccEn     <= 1'b0;
    end else if (strb.loadFields) begin
      fieldsQ.scratch   <= fieldsD.scratch;
      fieldsQ.marginEn  <= fieldsD.marginEn;
      fieldsQ.marginLvl <= fieldsD.marginLvl;
      fieldsQ.eccEn     <= fieldsD.eccEn;
    end
  end

  assign testEn = enQ;

  // read image; gated fields stand in as zero
  always_comb begin
    readOpen = enQ && opDone && integrityDone;
    rdData   = '0;
    if (rdEn) begin
      rdData[EN_POS] = enQ;
      if (readOpen) begin
        rdData[SYN_MSB:SYN_LSB] = fieldsQ.syndrome;
        rdData[SCRATCH_POS]     = fieldsQ.scratch;
        rdData[MRGEN_POS]       = fieldsQ.marginEn;
        rdData[MRGLVL_POS]      = fieldsQ.marginLvl;
        rdData[ECCEN_POS]       = fieldsQ.eccEn;
      end
    end
  end

  always_comb begin
    syndromeOut  = enQ ? fieldsQ.syndrome  : '0;
    marginEnOut  = enQ && fieldsQ.marginEn;
    marginLvlOut = enQ && fieldsQ.marginLvl;
    eccEnOut     = enQ && fieldsQ.eccEn;
  end

  // R5 / R6: fields hold unless the decoder grants a load
  p_fields_hold_r5: assert property (@(posedge clk) disable iff (!rstN)
    !strb.loadFields |=> $stable(fieldsQ));

  // R10: a granted load takes the write data in the next cycle
  p_fields_load_r10: assert property (@(posedge clk) disable iff (!rstN)
    strb.loadFields |=> fieldsQ == $past(fieldsD));

endmodule

// File: rtl/nvm_test_ctrl.sv
`timescale 1ns/1ps
module nvm_test_ctrl
  import nvm_test_ctrl_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic              rdEn,
  input  logic [DATA_W-1:0] wrData,
  output logic [DATA_W-1:0] rdData,
  input  logic              opDone,
  input  logic              integrityDone,
  output logic [SYN_W-1:0]  syndromeOut,
  output logic              marginEnOut,
  output logic              marginLvlOut,
  output logic              eccEnOut
);

  ctrlStrb_t strb;
  logic      testEn;

  nvm_test_ctrl_decode #(.KEY(UNLOCK_KEY)) u_decode (
    .wrEn          (wrEn),
    .wrData        (wrData),
    .testEn        (testEn),
    .opDone        (opDone),
    .integrityDone (integrityDone),
    .strb          (strb)
  );

  nvm_test_ctrl_datapath u_datapath (
    .clk           (clk),
    .rstN          (rstN),
    .strb          (strb),
    .wrData        (wrData),
    .rdEn          (rdEn),
    .opDone        (opDone),
    .integrityDone (integrityDone),
    .testEn        (testEn),
    .rdData        (rdData),
    .syndromeOut   (syndromeOut),
    .marginEnOut   (marginEnOut),
    .marginLvlOut  (marginLvlOut),
    .eccEnOut      (eccEnOut)
  );

  // R2 / R3: the flag only rises after a key write
  p_set_needs_key_r3: assert property (@(posedge clk) disable iff (!rstN)
    $rose(testEn) |-> ($past(wrEn) && $past(wrData) == UNLOCK_KEY));

  // R2: a key write raises the flag
  p_key_sets_r2: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && wrData == UNLOCK_KEY) |=> testEn);

  // R4: a write with bit 31 low clears the flag
  p_clear_r4: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && !wrData[EN_POS]) |=> !testEn);

  // R9: outputs stay inactive while locked
  p_out_locked_r9: assert property (@(posedge clk) disable iff (!rstN)
    !testEn |-> (syndromeOut == '0 && !marginEnOut && !marginLvlOut && !eccEnOut));

  // R7: reserved positions read zero
  p_rsvd_zero_r7: assert property (@(posedge clk) disable iff (!rstN)
    rdData[30:24] == '0 && rdData[15:7] == '0 && rdData[2:0] == '0);

  // R11: idle read bus is zero
  p_rd_idle_r11: assert property (@(posedge clk) disable iff (!rstN)
    !rdEn |-> rdData == '0);

endmodule

// File: tb/test_nvm_test_ctrl.sv
`timescale 1ns/1ps
module test_nvm_test_ctrl;

  localparam logic [31:0] KEY = 32'hF9F9_9999;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        wrEn = 1'b0;
  logic        rdEn = 1'b0;
  logic [31:0] wrData = '0;
  logic        opDone = 1'b1;
  logic        integrityDone = 1'b1;
  logic [31:0] rdData;
  logic [7:0]  syndromeOut;
  logic        marginEnOut, marginLvlOut, eccEnOut;

  nvm_test_ctrl i_nvm_test_ctrl (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .rdEn(rdEn), .wrData(wrData),
    .rdData(rdData), .opDone(opDone), .integrityDone(integrityDone),
    .syndromeOut(syndromeOut), .marginEnOut(marginEnOut),
    .marginLvlOut(marginLvlOut), .eccEnOut(eccEnOut)
  );

  always #2 clk = ~clk;

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  // bench model
  bit       mEn;
  bit [7:0] mSyn;
  bit       mScr, mMre, mMrv, mEie;

  function automatic logic [31:0] expRead();
    logic [31:0] r = '0;
    r[31] = mEn;
    if (mEn && opDone && integrityDone) begin
      r[23:16] = mSyn; r[6] = mScr; r[5] = mMre; r[4] = mMrv; r[3] = mEie;
    end
    return r;
  endfunction

  function automatic logic [11:0] expOuts();
    return mEn ? {mSyn, mMre, mMrv, mEie, 1'b0} : 12'h0;
  endfunction

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic checkState(string tag);
    rdEn = 1'b1;
    #1;
    chk({tag, " read image"}, rdData, expRead());
    chk({tag, " R9 outputs"}, {20'h0, syndromeOut, marginEnOut, marginLvlOut, eccEnOut, 1'b0},
        {20'h0, expOuts()});
    rdEn = 1'b0;
    #1;
    chk({tag, " R11 idle read"}, rdData, 32'h0);
  endtask

  task automatic busWrite(logic [31:0] d);
    bit acc;
    @(negedge clk);
    wrEn = 1'b1;
    wrData = d;
    @(posedge clk);
    #1;
    wrEn = 1'b0;
    acc = mEn && opDone && integrityDone;
    if (d == KEY) mEn = 1'b1;
    else begin
      if (acc) begin
        mSyn = d[23:16]; mScr = d[6]; mMre = d[5]; mMrv = d[4]; mEie = d[3];
      end
      if (!d[31]) mEn = 1'b0;
    end
    @(negedge clk);
  endtask

  task automatic finish();
    if (!finished) begin
      finished = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  endtask

  initial begin
    #(200000 * 4);
    errors++;
    $display("FAIL watchdog expired");
    finish();
  end

  initial begin
    void'($urandom(32'd20240611));
    repeat (4) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    checkState("R1 reset");

    busWrite(32'hFFFF_FFFF);
    checkState("R3 all-ones write while locked");
    busWrite(32'h00FF_0078);
    checkState("R5 field write while locked");

    busWrite(KEY);
    checkState("R2 key write, fields unchanged");
    busWrite(32'h80A5_0028);
    checkState("R8 layout syndrome A5 margin-en ecc-en");
    busWrite(32'hFFFF_FFFF);
    checkState("R7 R3 all ones keeps flag, reserved zero");
    busWrite(32'h8000_0000);
    checkState("R8 fields cleared");

    busWrite(32'h7FFF_FFFF);
    checkState("R10 R4 clear and load same cycle");
    busWrite(KEY);
    checkState("R10 R2 key reveals loaded fields");

    opDone = 1'b0;
    @(negedge clk);
    checkState("R6 opDone low hides fields");
    busWrite(32'h8000_0000);
    checkState("R6 write ignored with opDone low");
    opDone = 1'b1;
    integrityDone = 1'b0;
    busWrite(32'h8012_0010);
    integrityDone = 1'b1;
    @(negedge clk);
    checkState("R6 fields kept after integrityDone low write");

    for (int i = 0; i < 3000; i++) begin
      logic [31:0] d;
      opDone = ($urandom % 8) != 0;
      integrityDone = ($urandom % 8) != 0;
      d = (($urandom % 4) == 0) ? KEY : $urandom;
      busWrite(d);
      checkState("R2 R4 R5 R6 R7 R8 R9 random");
    end
    finish();
  end

endmodule